// File: doc/BRIEF.md
# Framed Synchronous Serial Port

This block moves fixed-length words between a parallel word interface and serial data lines. One receive section and up to three transmit sections each run from a bit clock and a frame-sync input that an external clock block provides. Frame sync marks where a word starts. It takes one of two forms. A level form stays active through every data bit of the word. A pulse form lasts one bit period and comes just before the first data bit. Transmit drives each data bit on the rising bit-clock edge. Receive samples on the falling edge. Words go most significant bit first.

The configuration inputs set four things. The first is whether receive borrows the transmit bit clock and frame sync (common mode) or uses its own pair (independent mode). The second is the frame-sync form. The third is whether the two directions use the same form or opposite forms. The fourth is the sync polarity. Word length is 8, 12, 16 or 24 bits. Software writes transmit words into per-lane holding registers and reads received words from a right-aligned data register. Empty, full, underrun and overrun flags report the state of the port. Receive and transmit each raise their own interrupt request. Bit clocks and frame syncs are sampled on the system clock, so they must be synchronous to it and much slower than it.

Top module: `ssp_port`

## Requirements
- R1: After reset every transmit lane reports empty, tx_sd is all zero, rx_full, rx_ovr and tx_udr are low, tx_irq is high and rx_irq is low.
- R2: In the level form, a transmit lane drives the MSB of its held word on the first rising bit-clock edge at which frame sync is active. It drives each following bit on each later rising edge, for exactly the word length.
- R3: In the pulse form, a rising edge that sees frame sync active arms the section. The MSB goes out on the next rising edge. Receive behaves the same way on falling edges.
- R4: Receive samples rx_sd on falling edges with the same framing rules. When the last bit of a word has been sampled, rx_data holds the word right-aligned with zero upper bits, and rx_full and rx_irq go high.
- R5: cfg_wlen selects the word length: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 24. Transmit ignores held bits above the word length.
- R6: Receive uses the pulse form when cfg_fs_bit is 1. Transmit uses the pulse form when cfg_fs_bit XOR cfg_fs_mix is 1. So with cfg_fs_mix at 0 both directions use the same form, and with it at 1 they use opposite forms.
- R7: Frame sync counts as active when the pin differs from cfg_fs_inv: active-high when cfg_fs_inv is 0, active-low when it is 1.
- R8: When cfg_sync is 1, receive takes its bit clock and frame sync from tx_sck and tx_fs, and rx_sck and rx_fs have no effect.
- R9: When cfg_sync is 0, lanes 1 and above hold tx_sd at 0, keep their held word and empty flag, never cause an underrun, and are left out of tx_irq.
- R10: A lane that is empty when its frame starts sends its previous word again and sets tx_udr. tx_udr stays set until any lane is written. A new underrun in the same cycle as a write wins.
- R11: A received word that completes while rx_full is still set, with no rx_rd in the same cycle, sets rx_ovr and replaces rx_data. A pulse on rx_rd clears rx_full and rx_ovr.
- R12: Writing a lane clears its empty flag, and the start of an active lane's frame sets it. tx_irq is high exactly when every active lane is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sync | input | 1 | 1: receive uses the transmit clock and sync |
| cfg_fs_bit | input | 1 | Frame-sync form select, 1 = pulse form |
| cfg_fs_mix | input | 1 | 1: transmit uses the opposite form to receive |
| cfg_fs_inv | input | 1 | 1: frame sync active-low |
| cfg_wlen | input | 2 | Word length code |
| tx_sck | input | 1 | Transmit (or common) bit clock |
| tx_fs | input | 1 | Transmit (or common) frame sync |
| rx_sck | input | 1 | Receive bit clock in independent mode |
| rx_fs | input | 1 | Receive frame sync in independent mode |
| rx_sd | input | 1 | Serial receive data |
| tx_sd | output | NTX | Serial transmit data, one per lane |
| tx_wr | input | NTX | Per-lane write strobe |
| tx_wdata | input | NTX*DW | Per-lane write words, lane i at bits i*DW upward |
| tx_empty | output | NTX | Per-lane empty flag |
| tx_udr | output | 1 | Sticky transmit underrun |
| rx_rd | input | 1 | Receive read strobe |
| rx_data | output | DW | Last received word, right-aligned |
| rx_full | output | 1 | Receive word waiting |
| rx_ovr | output | 1 | Sticky receive overrun |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions take four things for granted. Bit clocks and frame syncs change on the system clock. Each bit-clock level lasts at least one system clock. The configuration stays fixed while a word is in flight. A lane is not written in the same cycle its frame starts. The stimulus keeps within these limits. It holds each bit-clock phase for four system clocks, changes configuration only in the idle gaps between frames, and issues writes and reads only between frames. The pattern set covers both sync forms in each direction, both polarities, every word length, common and independent clocking, and back-to-back receive words without a read.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // Word length in bits for each cfg_wlen code.
  function automatic int unsigned wl_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 12;
      2'd2:    return 16;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/ssp_framer.sv
module ssp_framer #(
  parameter int CW   = 5,
  parameter bit RISE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          fs_act,
  input  logic          bit_fmt,
  input  logic [CW-1:0] wl,
  output logic          first,
  output logic          nxt,
  output logic          last
);
  logic          sck_q;
  logic          arm_q, arm_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ev, go;

  always_comb begin
    ev    = RISE ? (sck & ~sck_q) : (~sck & sck_q);
    go    = bit_fmt ? arm_q : fs_act;
    arm_d = arm_q;
    cnt_d = cnt_q;
    first = 1'b0;
    nxt   = 1'b0;
    if (ev) begin
      arm_d = fs_act;
      if (cnt_q == '0) begin
        if (go) begin
          first = 1'b1;
          cnt_d = wl - 1'b1;
        end
      end else begin
        nxt   = 1'b1;
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign last = nxt && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      sck_q <= sck;
      arm_q <= arm_d;
      cnt_q <= cnt_d;
    end
  end

  // R5: remaining-bit count never reaches the word length
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < wl);
endmodule

// File: rtl/ssp_tx_lane.sv
module ssp_tx_lane #(
  parameter int DW = 24,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          first,
  input  logic          nxt,
  input  logic [CW-1:0] wl,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          sd,
  output logic          empty,
  output logic          udr_hit
);
  logic [DW-1:0] data_q, data_d, sh_q, sh_d, lj;
  logic          sd_q, sd_d, emp_q, emp_d;

  assign lj = data_q << (CW'(DW) - wl);

  always_comb begin
    data_d = wr ? wdata : data_q;
    sh_d   = sh_q;
    sd_d   = sd_q;
    emp_d  = emp_q;
    if (!en) begin
      sd_d = 1'b0;
    end else if (first) begin
      sd_d = lj[DW-1];
      sh_d = lj << 1;
    end else if (nxt) begin
      sd_d = sh_q[DW-1];
      sh_d = sh_q << 1;
    end
    if (en && first) emp_d = 1'b1;
    if (wr)          emp_d = 1'b0;
  end

  assign udr_hit = en & first & emp_q;
  assign sd      = sd_q;
  assign empty   = emp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      sh_q   <= '0;
      sd_q   <= 1'b0;
      emp_q  <= 1'b1;
    end else begin
      data_q <= data_d;
      sh_q   <= sh_d;
      sd_q   <= sd_d;
      emp_q  <= emp_d;
    end
  end

  // R12: a write leaves the lane non-empty
  p_wr_fills_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !emp_q);
endmodule

// File: rtl/ssp_port.sv
module ssp_port #(
  parameter int NTX = 3,
  parameter int DW  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sync,
  input  logic              cfg_fs_bit,
  input  logic              cfg_fs_mix,
  input  logic              cfg_fs_inv,
  input  logic [1:0]        cfg_wlen,
  input  logic              tx_sck,
  input  logic              tx_fs,
  input  logic              rx_sck,
  input  logic              rx_fs,
  input  logic              rx_sd,
  output logic [NTX-1:0]    tx_sd,
  input  logic [NTX-1:0]    tx_wr,
  input  logic [NTX*DW-1:0] tx_wdata,
  output logic [NTX-1:0]    tx_empty,
  output logic              tx_udr,
  input  logic              rx_rd,
  output logic [DW-1:0]     rx_data,
  output logic              rx_full,
  output logic              rx_ovr,
  output logic              tx_irq,
  output logic              rx_irq
);
  localparam int CW = $clog2(DW + 1);

  logic [1:0]     rs_q;
  logic           rst_s;
  logic [CW-1:0]  wl;
  logic           tfs_act, rfs_act, rsck;
  logic           tx_first, tx_nxt, tx_last;
  logic           rx_first, rx_nxt, rx_last;
  logic [NTX-1:0] lane_en, udr_hit;
  logic [DW-1:0]  rsh_q, rsh_d, rdat_q, rdat_d;
  logic           full_q, full_d, ovr_q, ovr_d, udr_q, udr_d;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  assign wl      = CW'(ssp_pkg::wl_bits(cfg_wlen));
  assign tfs_act = tx_fs ^ cfg_fs_inv;
  assign rsck    = cfg_sync ? tx_sck : rx_sck;
  assign rfs_act = (cfg_sync ? tx_fs : rx_fs) ^ cfg_fs_inv;

  ssp_framer #(.CW(CW), .RISE(1'b1)) u_tx_frm (
    .clk(clk), .rst_n(rst_s), .sck(tx_sck), .fs_act(tfs_act),
    .bit_fmt(cfg_fs_bit ^ cfg_fs_mix), .wl(wl),
    .first(tx_first), .nxt(tx_nxt), .last(tx_last));

  ssp_framer #(.CW(CW), .RISE(1'b0)) u_rx_frm (
    .clk(clk), .rst_n(rst_s), .sck(rsck), .fs_act(rfs_act),
    .bit_fmt(cfg_fs_bit), .wl(wl),
    .first(rx_first), .nxt(rx_nxt), .last(rx_last));

  for (genvar i = 0; i < NTX; i++) begin : g_lane
    assign lane_en[i] = (i == 0) ? 1'b1 : cfg_sync;
    ssp_tx_lane #(.DW(DW), .CW(CW)) u_lane (
      .clk(clk), .rst_n(rst_s), .en(lane_en[i]),
      .first(tx_first), .nxt(tx_nxt), .wl(wl),
      .wr(tx_wr[i]), .wdata(tx_wdata[i*DW +: DW]),
      .sd(tx_sd[i]), .empty(tx_empty[i]), .udr_hit(udr_hit[i]));
  end

  always_comb begin
    rsh_d  = rsh_q;
    rdat_d = rdat_q;
    full_d = full_q;
    ovr_d  = ovr_q;
    if (rx_rd) begin
      full_d = 1'b0;
      ovr_d  = 1'b0;
    end
    if (rx_first) rsh_d = {{(DW-1){1'b0}}, rx_sd};
    else if (rx_nxt) rsh_d = {rsh_q[DW-2:0], rx_sd};
    if (rx_last) begin
      rdat_d = {rsh_q[DW-2:0], rx_sd};
      full_d = 1'b1;
      if (full_q && !rx_rd) ovr_d = 1'b1;
    end
    udr_d = udr_q;
    if (|tx_wr)   udr_d = 1'b0;
    if (|udr_hit) udr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rsh_q  <= '0;
      rdat_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      udr_q  <= 1'b0;
    end else begin
      rsh_q  <= rsh_d;
      rdat_q <= rdat_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
      udr_q  <= udr_d;
    end
  end

  assign rx_data = rdat_q;
  assign rx_full = full_q;
  assign rx_ovr  = ovr_q;
  assign tx_udr  = udr_q;
  assign rx_irq  = full_q;
  assign tx_irq  = &(tx_empty | ~lane_en);

  // R11: overrun only follows a pending word
  p_ovr_needs_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_full));
  // R4: full rises only after the last receive bit
  p_full_from_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_last));
  // R10: underrun rises only from a lane starting empty
  p_udr_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_udr) |-> $past(|udr_hit));
  // R5: after the final transmit bit no further bit of that word follows
  p_word_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |=> !tx_nxt);
  if (NTX > 1) begin : g_idle_chk
    // R9: extra lanes stay quiet in independent mode
    p_idle_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_sync && $past(!cfg_sync)) |-> (tx_sd[NTX-1:1] == '0));
  end
endmodule

// File: tb/ssp_port_bench.sv
module ssp_port_bench;
  localparam int NTX = 3;
  localparam int DW  = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_sync, cfg_fs_bit, cfg_fs_mix, cfg_fs_inv;
  logic [1:0] cfg_wlen;
  logic tx_sck, tx_fs, rx_sck, rx_fs, rx_sd;
  logic [NTX-1:0] tx_sd, tx_wr, tx_empty;
  logic [NTX*DW-1:0] tx_wdata;
  logic tx_udr, rx_rd, rx_full, rx_ovr, tx_irq, rx_irq;
  logic [DW-1:0] rx_data;

  int n_chk = 0;
  int n_fail = 0;
  bit run = 0;
  bit rx_clk_on = 1;
  bit rx_fs_junk = 0;
  int cap [NTX];

  always #5 clk = ~clk;

  ssp_port #(.NTX(NTX), .DW(DW)) u_ssp_port (
    .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_fs_bit(cfg_fs_bit),
    .cfg_fs_mix(cfg_fs_mix), .cfg_fs_inv(cfg_fs_inv), .cfg_wlen(cfg_wlen),
    .tx_sck(tx_sck), .tx_fs(tx_fs), .rx_sck(rx_sck), .rx_fs(rx_fs),
    .rx_sd(rx_sd), .tx_sd(tx_sd), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .tx_empty(tx_empty), .tx_udr(tx_udr), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_full(rx_full), .rx_ovr(rx_ovr), .tx_irq(tx_irq), .rx_irq(rx_irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wlb(input logic [1:0] c);
    return (c == 0) ? 8 : (c == 1) ? 12 : (c == 2) ? 16 : 24;
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_tc, m_rc, m_rdat, m_racc, m_wl;
  bit m_tp, m_rp, m_tarm, m_rarm, m_udr, m_full, m_ovr;
  int m_dat [NTX];
  int m_word [NTX];
  bit m_emp [NTX];
  bit m_sd [NTX];
  bit t_fa, r_fa, r_ck, go_t, go_r, hit, done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tc = 0; m_rc = 0; m_rdat = 0; m_racc = 0;
      m_tp = 0; m_rp = 0; m_tarm = 0; m_rarm = 0;
      m_udr = 0; m_full = 0; m_ovr = 0;
      for (int i = 0; i < NTX; i++) begin
        m_dat[i] = 0; m_word[i] = 0; m_emp[i] = 1; m_sd[i] = 0;
      end
    end else begin
      m_wl = wlb(cfg_wlen);
      t_fa = tx_fs ^ cfg_fs_inv;
      r_ck = cfg_sync ? tx_sck : rx_sck;
      r_fa = (cfg_sync ? tx_fs : rx_fs) ^ cfg_fs_inv;
      hit = 0; done = 0;
      if (tx_sck && !m_tp) begin
        go_t = (cfg_fs_bit ^ cfg_fs_mix) ? m_tarm : t_fa;
        m_tarm = t_fa;
        if (m_tc == 0 && go_t) begin
          m_tc = m_wl;
          for (int i = 0; i < NTX; i++)
            if (i == 0 || cfg_sync) begin
              if (m_emp[i]) hit = 1;
              m_emp[i] = 1;
              m_word[i] = m_dat[i];
            end
        end else if (m_tc == 0) begin
          m_tc = 0;
        end
        if (m_tc > 0) begin
          for (int i = 0; i < NTX; i++)
            if (i == 0 || cfg_sync) m_sd[i] = m_word[i][m_tc-1];
          m_tc--;
        end
      end
      for (int i = 1; i < NTX; i++) if (!cfg_sync) m_sd[i] = 0;
      if (!r_ck && m_rp) begin
        go_r = cfg_fs_bit ? m_rarm : r_fa;
        m_rarm = r_fa;
        if (m_rc == 0 && go_r) begin m_rc = m_wl; m_racc = 0; end
        if (m_rc > 0) begin
          m_racc = m_racc * 2 + int'(rx_sd);
          m_rc--;
          if (m_rc == 0) done = 1;
        end
      end
      if (rx_rd) begin m_full = 0; m_ovr = 0; end
      if (done) begin
        if (m_full && !rx_rd) m_ovr = 1;
        m_full = 1;
        m_rdat = m_racc;
      end
      for (int i = 0; i < NTX; i++)
        if (tx_wr[i]) begin
          m_dat[i] = int'(tx_wdata[i*DW +: DW]);
          m_emp[i] = 0;
        end
      if (|tx_wr) m_udr = 0;
      if (hit) m_udr = 1;
      m_tp = tx_sck;
      m_rp = r_ck;
    end
  end

  // compare on every clock, between active edges
  always @(negedge clk) begin
    if (run) begin
      bit irq_e;
      irq_e = 1;
      for (int i = 0; i < NTX; i++) begin
        chk(tx_sd[i] == m_sd[i], "R2 tx_sd", int'(tx_sd[i]), int'(m_sd[i]));
        chk(tx_empty[i] == m_emp[i], "R12 tx_empty", int'(tx_empty[i]), int'(m_emp[i]));
        if ((i == 0 || cfg_sync) && !m_emp[i]) irq_e = 0;
      end
      chk(tx_udr == m_udr, "R10 tx_udr", int'(tx_udr), int'(m_udr));
      chk(int'(rx_data) == m_rdat, "R4 rx_data", int'(rx_data), m_rdat);
      chk(rx_full == m_full, "R4 rx_full", int'(rx_full), int'(m_full));
      chk(rx_ovr == m_ovr, "R11 rx_ovr", int'(rx_ovr), int'(m_ovr));
      chk(tx_irq == irq_e, "R12 tx_irq", int'(tx_irq), int'(irq_e));
      chk(rx_irq == m_full, "R4 rx_irq", int'(rx_irq), int'(m_full));
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic do_bit(input bit tfa, input bit rfa, input bit sd, input bit grab);
    tx_sck = 1'b1;
    if (rx_clk_on) rx_sck = 1'b1;
    tx_fs = tfa ^ cfg_fs_inv;
    rx_fs = (rfa ^ cfg_fs_inv) ^ rx_fs_junk;
    rx_sd = sd;
    repeat (4) tick();
    tx_sck = 1'b0;
    rx_sck = 1'b0;
    if (grab)
      for (int i = 0; i < NTX; i++) cap[i] = (cap[i] << 1) | int'(tx_sd[i]);
    repeat (4) tick();
  endtask

  task automatic frame(input int wl, input bit tbit, input bit rbit, input int word);
    for (int i = 0; i < NTX; i++) cap[i] = 0;
    if (tbit || rbit) do_bit(tbit, rbit, 1'b0, 1'b0);
    for (int b = wl - 1; b >= 0; b--) do_bit(!tbit, !rbit, word[b], 1'b1);
    do_bit(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wr_lane(input int i, input int val);
    tx_wdata[i*DW +: DW] = val[DW-1:0];
    tx_wr[i] = 1'b1;
    tick();
    tx_wr = '0;
    tick();
  endtask

  task automatic rd_pulse();
    rx_rd = 1'b1;
    tick();
    rx_rd = 1'b0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_sync = 0; cfg_fs_bit = 0; cfg_fs_mix = 0; cfg_fs_inv = 0; cfg_wlen = 2'd0;
    tx_sck = 0; tx_fs = 0; rx_sck = 0; rx_fs = 0; rx_sd = 0;
    tx_wr = '0; tx_wdata = '0; rx_rd = 0;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    run = 1;
    // R1 reset state
    chk(tx_empty == 3'b111, "R1 tx_empty", int'(tx_empty), 7);
    chk(tx_sd == 3'b000, "R1 tx_sd", int'(tx_sd), 0);
    chk(!rx_full && !rx_ovr && !tx_udr, "R1 flags", int'({rx_full, rx_ovr, tx_udr}), 0);
    chk(tx_irq && !rx_irq, "R1 irq", int'({tx_irq, rx_irq}), 2);

    // independent mode, level form, 8 bits
    wr_lane(0, 'h3C5);
    wr_lane(1, 'hAB);
    chk(tx_empty[0] == 0, "R12 write clears empty", int'(tx_empty[0]), 0);
    chk(tx_irq == 0, "R12 tx_irq low", int'(tx_irq), 0);
    frame(8, 0, 0, 'hA5);
    chk(cap[0] == 'hC5, "R2 level-form word R5 truncation", cap[0], 'hC5);
    chk(cap[1] == 0, "R9 idle lane sd", cap[1], 0);
    chk(tx_empty[1] == 0, "R9 idle lane keeps word", int'(tx_empty[1]), 0);
    chk(tx_irq == 1, "R9 tx_irq ignores idle lane", int'(tx_irq), 1);
    chk(int'(rx_data) == 'hA5 && rx_full, "R4 receive word", int'(rx_data), 'hA5);
    chk(tx_udr == 0, "R9 no underrun", int'(tx_udr), 0);
    rd_pulse();
    chk(rx_full == 0, "R11 read clears full", int'(rx_full), 0);

    // pulse form both directions, 12 bits
    cfg_fs_bit = 1; cfg_wlen = 2'd1;
    wr_lane(0, 'hABC);
    frame(12, 1, 1, 'h5A3);
    chk(cap[0] == 'hABC, "R3 pulse-form transmit", cap[0], 'hABC);
    chk(int'(rx_data) == 'h5A3, "R3 pulse-form receive R5", int'(rx_data), 'h5A3);
    rd_pulse();

    // mixed forms, 16 bits: receive level, transmit pulse
    cfg_fs_bit = 0; cfg_fs_mix = 1; cfg_wlen = 2'd2;
    wr_lane(0, 'h1234);
    frame(16, 1, 0, 'hBEEF);
    chk(cap[0] == 'h1234, "R6 tx pulse rx level", cap[0], 'h1234);
    chk(int'(rx_data) == 'hBEEF, "R6 rx level", int'(rx_data), 'hBEEF);
    rd_pulse();
    // receive pulse, transmit level
    cfg_fs_bit = 1;
    wr_lane(0, 'h8001);
    frame(16, 0, 1, 'h0F0F);
    chk(cap[0] == 'h8001, "R6 tx level rx pulse", cap[0], 'h8001);
    chk(int'(rx_data) == 'h0F0F, "R6 rx pulse", int'(rx_data), 'h0F0F);
    rd_pulse();

    // inverted sync, 12 bits, level form
    cfg_fs_bit = 0; cfg_fs_mix = 0; cfg_fs_inv = 1; cfg_wlen = 2'd1;
    tx_fs = 1; rx_fs = 1;
    repeat (2) tick();
    wr_lane(0, 'h777);
    frame(12, 0, 0, 'h9C1);
    chk(cap[0] == 'h777, "R7 inverted sync tx", cap[0], 'h777);
    chk(int'(rx_data) == 'h9C1, "R7 inverted sync rx", int'(rx_data), 'h9C1);
    rd_pulse();

    // common mode, 24 bits, three lanes, receive pins scrambled
    cfg_fs_inv = 0; cfg_sync = 1; cfg_wlen = 2'd3;
    tx_fs = 0; rx_fs = 0;
    repeat (2) tick();
    rx_clk_on = 0; rx_fs_junk = 1;
    wr_lane(0, 'h123456);
    wr_lane(1, 'hABCDEF);
    wr_lane(2, 'h800001);
    frame(24, 0, 0, 'hC0FFEE);
    chk(cap[0] == 'h123456, "R8 lane0 common mode", cap[0], 'h123456);
    chk(cap[1] == 'hABCDEF, "R8 lane1 common mode", cap[1], 'hABCDEF);
    chk(cap[2] == 'h800001, "R8 lane2 common mode", cap[2], 'h800001);
    chk(int'(rx_data) == 'hC0FFEE, "R8 rx on common clock", int'(rx_data), 'hC0FFEE);
    chk(tx_irq == 1, "R12 all active lanes empty", int'(tx_irq), 1);
    rd_pulse();

    // underrun: no new words
    frame(24, 0, 0, 'h000F00);
    chk(tx_udr == 1, "R10 underrun set", int'(tx_udr), 1);
    chk(cap[0] == 'h123456, "R10 previous word resent", cap[0], 'h123456);
    wr_lane(0, 'h55);
    chk(tx_udr == 0, "R10 write clears underrun", int'(tx_udr), 0);
    rd_pulse();

    // overrun in independent mode, 8 bits
    cfg_sync = 0; cfg_wlen = 2'd0; rx_clk_on = 1; rx_fs_junk = 0;
    rx_fs = 0;
    repeat (2) tick();
    frame(8, 0, 0, 'h11);
    chk(rx_ovr == 0, "R11 first word no overrun", int'(rx_ovr), 0);
    frame(8, 0, 0, 'h9E);
    chk(rx_ovr == 1 && rx_full, "R11 overrun set", int'(rx_ovr), 1);
    chk(int'(rx_data) == 'h9E, "R11 newer word kept", int'(rx_data), 'h9E);
    rd_pulse();
    chk(!rx_ovr && !rx_full, "R11 read clears flags", int'({rx_ovr, rx_full}), 0);

    run = 0;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule